// File: doc/BRIEF.md
# Serial Wake Sequence Detector

This block holds the power state of a serial-to-radio bridge and brings it back to normal operation when the host sends a fixed wake pattern. A one-byte power-state register selects one of three states: awake, sleep or standby. While the unit is in sleep or standby, the radio is off and no received byte is passed on. The block watches the incoming serial bytes for an unbroken run of 0xFF bytes.

When the run is complete, the block clears the power-state register and enters a waking phase. The waking phase lasts a number of timebase ticks, and that number depends on whether the unit was asleep or in standby. Bytes that arrive during the waking phase are dropped. Once the waking phase ends, forwarding resumes, so the next byte after the wake pattern and the delay goes out as normal payload. The tick is an external pulse, for example one every 100 µs.

Top module: `serial_wake_detector`

## Requirements
- R1: After a synchronous reset, `state` is 2'b00 (awake), `pwr_reg` is 0x00, `radio_en` and `fwd_en` are 1, and `fwd_valid` is 0.
- R2: In the awake state, a register write of 0x01 moves `state` to 2'b01 (sleep) and of 0x02 moves it to 2'b10 (standby). In both cases `pwr_reg` holds the written value from the next cycle. A write of any other value leaves `state` and `pwr_reg` unchanged.
- R3: In sleep or standby, `radio_en` and `fwd_en` are 0, and received bytes never raise `fwd_valid`.
- R4: In sleep or standby, the cycle after the WAKE_RUN-th consecutive 0xFF byte (4 by default), `state` reads 2'b11 (waking) and `pwr_reg` reads 0x00.
- R5: In sleep or standby, any byte other than 0xFF restarts the count, so a full new run of WAKE_RUN 0xFF bytes is needed after it.
- R6: The waking state lasts exactly SLEEP_TICKS tick pulses when entered from sleep and STBY_TICKS tick pulses when entered from standby. The cycle after the last pulse, `state` is 2'b00.
- R7: During waking, `radio_en` is 1 and `fwd_en` is 0, and received bytes are discarded (no `fwd_valid`).
- R8: In the awake state, every received byte appears on `fwd_data` with `fwd_valid` high for one cycle, one cycle after its strobe.
- R9: A reset taken partway through a wake run returns `state` to awake and discards the partial run.
- R10: Register writes are ignored while the state is sleep, standby or waking.
- R11: 0xFF bytes received while awake are forwarded as data and do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe for a received serial byte |
| byte_data | input | 8 | Received serial byte |
| pwr_wr | input | 1 | Power-state register write strobe |
| pwr_wdata | input | 8 | Value written to the power-state register |
| tick | input | 1 | Timebase pulse that paces the wake delay |
| state | output | 2 | 00 awake, 01 sleep, 10 standby, 11 waking |
| pwr_reg | output | 8 | Current power-state register value |
| radio_en | output | 1 | Radio enable |
| fwd_en | output | 1 | High while received bytes are forwarded |
| fwd_valid | output | 1 | Forwarded byte strobe |
| fwd_data | output | 8 | Forwarded byte |

## Verification
The bench builds the block with SLEEP_TICKS = 5 and STBY_TICKS = 2, and keeps WAKE_RUN at its default of 4. These short delays let the bench observe the last tick of both wake delays, one pulse before the exit and at the exit, in a few dozen cycles. The default run length exercises the real pattern, including a run broken after three 0xFF bytes and a run cut short by reset.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [1:0] {
        PS_AWAKE  = 2'b00,
        PS_SLEEP  = 2'b01,
        PS_STBY   = 2'b10,
        PS_WAKING = 2'b11
    } pstate_e;

    localparam logic [7:0] REG_AWAKE = 8'h00;
    localparam logic [7:0] REG_SLEEP = 8'h01;
    localparam logic [7:0] REG_STBY  = 8'h02;
    localparam logic [7:0] WAKE_BYTE = 8'hFF;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_t;

    function automatic logic is_dormant(input pstate_e s);
        return (s == PS_SLEEP) || (s == PS_STBY);
    endfunction

    function automatic logic radio_on(input pstate_e s);
        return (s == PS_AWAKE) || (s == PS_WAKING);
    endfunction

endpackage

// File: rtl/swd_run_counter.sv
module swd_run_counter
    import swd_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  armed,
    input  byte_t byte_in,
    output logic  hit
);
    localparam int CW = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);

    logic [CW-1:0] run_q;
    logic          is_wake;

    assign is_wake = byte_in.valid && (byte_in.data == WAKE_BYTE);
    assign hit     = armed && is_wake && (run_q == CW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            run_q <= '0;
        end else if (byte_in.valid) begin
            if (is_wake && !hit)
                run_q <= run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

endmodule

// File: rtl/swd_delay_timer.sv
module swd_delay_timer #(
    parameter int SLEEP_TICKS = 78,
    parameter int STBY_TICKS  = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic from_sleep,
    input  logic tick,
    output logic done
);
    localparam int MAXT = (SLEEP_TICKS > STBY_TICKS) ? SLEEP_TICKS : STBY_TICKS;
    localparam int TW   = (MAXT < 2) ? 1 : $clog2(MAXT + 1);

    logic          busy_q;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] last_q;

    assign done = busy_q && tick && (cnt_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            last_q <= from_sleep ? TW'(SLEEP_TICKS - 1) : TW'(STBY_TICKS - 1);
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/swd_forwarder.sv
module swd_forwarder
    import swd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  byte_t byte_in,
    output byte_t byte_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out <= '0;
        end else begin
            byte_out.valid <= enable && byte_in.valid;
            if (enable && byte_in.valid)
                byte_out.data <= byte_in.data;
        end
    end

endmodule

// File: rtl/serial_wake_detector.sv
module serial_wake_detector
    import swd_pkg::*;
#(
    parameter int WAKE_RUN    = 4,
    parameter int SLEEP_TICKS = 78,
    parameter int STBY_TICKS  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       pwr_wr,
    input  logic [7:0] pwr_wdata,
    input  logic       tick,
    output logic [1:0] state,
    output logic [7:0] pwr_reg,
    output logic       radio_en,
    output logic       fwd_en,
    output logic       fwd_valid,
    output logic [7:0] fwd_data
);
    pstate_e    st_q;
    logic [7:0] reg_q;
    byte_t      rx_byte;
    byte_t      fwd_byte;
    logic       run_hit;
    logic       delay_done;

    assign rx_byte.valid = byte_valid;
    assign rx_byte.data  = byte_data;

    swd_run_counter #(.RUN_LEN(WAKE_RUN)) u_run (
        .clk     (clk),
        .rst     (rst),
        .armed   (is_dormant(st_q)),
        .byte_in (rx_byte),
        .hit     (run_hit)
    );

    swd_delay_timer #(.SLEEP_TICKS(SLEEP_TICKS), .STBY_TICKS(STBY_TICKS)) u_delay (
        .clk        (clk),
        .rst        (rst),
        .start      (run_hit),
        .from_sleep (st_q == PS_SLEEP),
        .tick       (tick),
        .done       (delay_done)
    );

    swd_forwarder u_fwd (
        .clk      (clk),
        .rst      (rst),
        .enable   (st_q == PS_AWAKE),
        .byte_in  (rx_byte),
        .byte_out (fwd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_AWAKE;
            reg_q <= REG_AWAKE;
        end else begin
            unique case (st_q)
                PS_AWAKE: begin
                    if (pwr_wr && pwr_wdata == REG_SLEEP) begin
                        st_q  <= PS_SLEEP;
                        reg_q <= REG_SLEEP;
                    end else if (pwr_wr && pwr_wdata == REG_STBY) begin
                        st_q  <= PS_STBY;
                        reg_q <= REG_STBY;
                    end
                end
                PS_SLEEP, PS_STBY: begin
                    if (run_hit) begin
                        st_q  <= PS_WAKING;
                        reg_q <= REG_AWAKE;
                    end
                end
                PS_WAKING: begin
                    if (delay_done)
                        st_q <= PS_AWAKE;
                end
                default: st_q <= PS_AWAKE;
            endcase
        end
    end

    assign state     = st_q;
    assign pwr_reg   = reg_q;
    assign radio_en  = radio_on(st_q);
    assign fwd_en    = (st_q == PS_AWAKE);
    assign fwd_valid = fwd_byte.valid;
    assign fwd_data  = fwd_byte.data;

endmodule

// File: rtl/swd_checker.sv
module swd_checker (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       pwr_wr,
    input logic [7:0] pwr_wdata,
    input logic       tick,
    input logic [1:0] state,
    input logic [7:0] pwr_reg,
    input logic       radio_en,
    input logic       fwd_valid,
    input logic [7:0] fwd_data
);
    // R2: sleep entry from awake
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b00 && pwr_wr && pwr_wdata == 8'h01) |=> (state == 2'b01 && pwr_reg == 8'h01));

    // R3: radio is off while dormant
    a_r3_radio_off: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b01 || state == 2'b10) |-> !radio_en);

    // R4: the register reads cleared throughout waking
    a_r4_reg_cleared: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11) |-> (pwr_reg == 8'h00));

    // R6: waking cannot end without a tick
    a_r6_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && !tick) |=> (state == 2'b11));

    // R7: no forwarding outside awake
    a_r7_no_fwd: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && state != 2'b00) |=> !fwd_valid);

    // R8: awake bytes come out one cycle later
    a_r8_fwd_byte: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && state == 2'b00) |=> (fwd_valid && fwd_data == $past(byte_data)));

    // R10: writes while dormant leave the register alone
    a_r10_write_ignored: assert property (@(posedge clk) disable iff (rst)
        ((state == 2'b01 || state == 2'b10) && pwr_wr && !byte_valid) |=> $stable(pwr_reg));
endmodule

bind serial_wake_detector swd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pwr_wr     (pwr_wr),
    .pwr_wdata  (pwr_wdata),
    .tick       (tick),
    .state      (state),
    .pwr_reg    (pwr_reg),
    .radio_en   (radio_en),
    .fwd_valid  (fwd_valid),
    .fwd_data   (fwd_data)
);

// File: tb/serial_wake_detector_tb.sv
module serial_wake_detector_tb;
    localparam int SLP = 5;
    localparam int STB = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       pwr_wr = 1'b0;
    logic [7:0] pwr_wdata = 8'h00;
    logic       tick = 1'b0;
    logic [1:0] state;
    logic [7:0] pwr_reg;
    logic       radio_en, fwd_en, fwd_valid;
    logic [7:0] fwd_data;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    serial_wake_detector #(.WAKE_RUN(4), .SLEEP_TICKS(SLP), .STBY_TICKS(STB)) u_dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata), .tick(tick),
        .state(state), .pwr_reg(pwr_reg), .radio_en(radio_en), .fwd_en(fwd_en),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_valid = 1'b1;
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] d);
        pwr_wr    = 1'b1;
        pwr_wdata = d;
        @(negedge clk);
        pwr_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        do_reset();
        chk("R1", "state", state, 2'b00);
        chk("R1", "pwr_reg", pwr_reg, 8'h00);
        chk("R1", "radio_en", radio_en, 1);
        chk("R1", "fwd_en", fwd_en, 1);
        chk("R1", "fwd_valid", fwd_valid, 0);
    endtask

    task automatic t_standby_wake();
        write_reg(8'h05);
        chk("R2", "state after bad write", state, 2'b00);
        chk("R2", "reg after bad write", pwr_reg, 8'h00);
        write_reg(8'h02);
        chk("R2", "standby state", state, 2'b10);
        chk("R2", "standby reg", pwr_reg, 8'h02);
        chk("R3", "radio off standby", radio_en, 0);
        chk("R3", "fwd off standby", fwd_en, 0);
        write_reg(8'h00);
        chk("R10", "write in standby", state, 2'b10);
        chk("R10", "reg in standby", pwr_reg, 8'h02);
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        chk("R4", "three FF still standby", state, 2'b10);
        send_byte(8'hFF);
        chk("R4", "waking", state, 2'b11);
        chk("R4", "reg cleared", pwr_reg, 8'h00);
        chk("R7", "radio on waking", radio_en, 1);
        chk("R7", "fwd off waking", fwd_en, 0);
        send_byte(8'h5A);
        chk("R7", "byte dropped waking", fwd_valid, 0);
        for (int i = 0; i < STB - 1; i++) pulse_tick();
        chk("R6", "standby delay not done", state, 2'b11);
        pulse_tick();
        chk("R6", "standby delay done", state, 2'b00);
        send_byte(8'h41);
        chk("R8", "fwd_valid", fwd_valid, 1);
        chk("R8", "fwd_data", fwd_data, 8'h41);
        @(negedge clk);
        chk("R8", "fwd_valid one cycle", fwd_valid, 0);
    endtask

    task automatic t_sleep_wake();
        write_reg(8'h01);
        chk("R2", "sleep state", state, 2'b01);
        chk("R2", "sleep reg", pwr_reg, 8'h01);
        send_byte(8'h33);
        chk("R3", "no fwd sleep", fwd_valid, 0);
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        send_byte(8'h00);
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        chk("R5", "broken run stays asleep", state, 2'b01);
        send_byte(8'hFF);
        chk("R4", "sleep waking", state, 2'b11);
        for (int i = 0; i < SLP - 1; i++) pulse_tick();
        chk("R6", "sleep delay not done", state, 2'b11);
        pulse_tick();
        chk("R6", "sleep delay done", state, 2'b00);
        send_byte(8'hFF);
        chk("R11", "FF forwarded awake", fwd_valid, 1);
        chk("R11", "FF data", fwd_data, 8'hFF);
        chk("R11", "state stays awake", state, 2'b00);
    endtask

    task automatic t_reset_mid();
        write_reg(8'h01);
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        do_reset();
        chk("R9", "reset to awake", state, 2'b00);
        write_reg(8'h01);
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        chk("R9", "partial run discarded", state, 2'b01);
        send_byte(8'hFF);
        chk("R9", "fresh run wakes", state, 2'b11);
        for (int i = 0; i < SLP; i++) pulse_tick();
        chk("R9", "awake again", state, 2'b00);
    endtask

    initial begin
        t_reset();
        t_standby_wake();
        t_sleep_wake();
        t_reset_mid();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule